// File: doc/BRIEF.md
# Prioritised Restart Interrupt Controller

This block decides which of five interrupt sources an 8-bit processor core should service next. The sources are a non-maskable trap, three restart inputs (called levels 7, 6 and 5 here, 7 being the most urgent) and one general interrupt request. The core raises a strobe at every instruction boundary. On that strobe the controller takes a snapshot of all sources, picks a winner by fixed priority, and for one cycle presents the winning source together with the 16-bit restart address to load into the program counter.

The controller holds the interrupt-enable flag and one mask bit per restart input. The core sets and clears both. Accepting any interrupt clears the enable flag, so that no nested maskable interrupt is taken until software enables interrupts again. The general request carries no fixed address. For that source the controller only reports the win and pulses a separate acknowledge, and the core fetches the vector through its own acknowledge cycle.

The trap and the level-7 restart are edge-triggered and are caught in latches. The trap latch also needs the input to stay high until it is sampled. The level-6 and level-5 restarts and the general request are level-sensitive. An unmasked status word shows which sources are currently requesting.

Top module: `restart_irq_ctrl`

## Requirements
- R1: Among eligible sources the winner follows the order nmi > rs7 > rs6 > rs5 > general. The code on src_o is 5 for nmi, 4 for rs7, 3 for rs6, 2 for rs5, 1 for general and 0 when nothing is granted.
- R2: An nmi latched at a boundary is granted whatever the enable flag and the mask bits are.
- R3: vector_o carries 0x0024 for nmi, 0x003C for rs7, 0x0034 for rs6, 0x002C for rs5, and 0x0000 for the general request and for idle cycles.
- R4: A grant occurs only in the cycle after a clock edge at which boundary_i was high and a source was eligible. Without boundary_i, take_o stays low.
- R5: A synchronous reset leaves take_o, gen_ack_o, src_o, vector_o and ie_o at 0. It sets all three mask bits and empties both edge latches.
- R6: Any grant clears the enable flag on the same edge. Otherwise ie_clr_i clears the flag and ie_set_i sets it, and clear wins when both are high.
- R7: A restart whose mask bit is set never wins. It still shows in pend_o. The mask bits are bit 0 for rs5, bit 1 for rs6 and bit 2 for rs7.
- R8: A rising edge on rs7_i is latched until rs7 is granted. rs6_i, rs5_i and gen_req_i count only while high.
- R9: A rising edge on nmi_i is latched only while nmi_i stays high. A pulse that falls before the boundary is lost, and a level held high causes exactly one grant.
- R10: take_o, src_o and vector_o hold for exactly one cycle. gen_ack_o pulses together with take_o only when the general request wins.
- R11: pending_o is high in the same cycle that any source is eligible. pend_o shows the unmasked requests as bit 4 nmi latch, bit 3 rs7 latch, bit 2 rs6, bit 1 rs5 and bit 0 general.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction boundary strobe (sample point) |
| nmi_i | input | 1 | Non-maskable trap request |
| rs7_i | input | 1 | Restart level 7, edge-triggered |
| rs6_i | input | 1 | Restart level 6, level-sensitive |
| rs5_i | input | 1 | Restart level 5, level-sensitive |
| gen_req_i | input | 1 | General interrupt request, level-sensitive |
| ie_set_i | input | 1 | Core sets the enable flag |
| ie_clr_i | input | 1 | Core clears the enable flag |
| mask_wr_i | input | 1 | Write strobe for the mask bits |
| mask_i | input | 3 | New mask bits (bit 0 rs5, bit 1 rs6, bit 2 rs7) |
| pending_o | output | 1 | Some source is eligible now |
| take_o | output | 1 | One-cycle grant pulse |
| src_o | output | 3 | Granted source code |
| vector_o | output | 16 | Restart address for the granted source |
| gen_ack_o | output | 1 | Acknowledge pulse for the general request |
| ie_o | output | 1 | Current enable flag |
| pend_o | output | 5 | Unmasked request status |

## Verification
On every cycle the assertions check the following:
- a grant never appears without a boundary strobe;
- the source code is never idle while take_o is high;
- a latched trap always wins at the next boundary;
- a masked restart never wins;
- the enable flag is low after any grant;
- the edge latches follow their inputs.

Other behaviours can only be shown by the bench's scenarios:
- the full priority order across mixed mask and request patterns;
- the exact restart addresses;
- that a trap held high fires only once and a short trap pulse is lost;
- that rs7 is not retaken after its acknowledge while rs6 is retaken because its level persists.

// File: rtl/rirq_pkg.sv
package rirq_pkg;

    localparam int NUM_RST = 3;
    localparam int VEC_W   = 16;
    localparam int STAT_W  = NUM_RST + 2;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_GEN  = 3'd1,
        SRC_R5   = 3'd2,
        SRC_R6   = 3'd3,
        SRC_R7   = 3'd4,
        SRC_NMI  = 3'd5
    } src_e;

    typedef struct packed {
        logic nmi;
        logic r7;
        logic r6;
        logic r5;
        logic gen;
    } req_s;

    typedef struct packed {
        logic             take;
        src_e             src;
        logic [VEC_W-1:0] vec;
        logic             gen_ack;
    } grant_s;

    function automatic src_e pick_src(req_s e);
        src_e s;
        if (e.nmi)      s = SRC_NMI;
        else if (e.r7)  s = SRC_R7;
        else if (e.r6)  s = SRC_R6;
        else if (e.r5)  s = SRC_R5;
        else if (e.gen) s = SRC_GEN;
        else            s = SRC_NONE;
        return s;
    endfunction

    // Restart slot n lands at 8*n + 4; the slots are 4..7
    function automatic logic [VEC_W-1:0] vec_of(src_e s);
        logic [2:0] slot;
        logic       has;
        has  = 1'b1;
        slot = 3'd0;
        case (s)
            SRC_NMI: slot = 3'd4;
            SRC_R5:  slot = 3'd5;
            SRC_R6:  slot = 3'd6;
            SRC_R7:  slot = 3'd7;
            default: has  = 1'b0;
        endcase
        return has ? VEC_W'({slot, 3'b100}) : '0;
    endfunction

endpackage

// File: rtl/rirq_edge_latch.sv
module rirq_edge_latch #(
    parameter bit NEED_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_i,
    input  logic clr_i,
    output logic lat_o
);
    logic prev_q;
    logic rise;

    assign rise = in_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= in_i;
    end

    generate
        if (NEED_LEVEL) begin : g_level
            always_ff @(posedge clk) begin
                if (rst) lat_o <= 1'b0;
                else     lat_o <= ((lat_o & ~clr_i) | rise) & in_i;
            end

            // R9
            level_held_chk: assert property (@(posedge clk) disable iff (rst)
                lat_o |-> $past(in_i));
        end else begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst) lat_o <= 1'b0;
                else     lat_o <= (lat_o & ~clr_i) | rise;
            end

            // R8
            sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (lat_o && !clr_i) |=> lat_o);
        end
    endgenerate

    // R8
    edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (in_i && !prev_q) |=> lat_o);

endmodule

// File: rtl/rirq_enable_reg.sv
module rirq_enable_reg
    import rirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ie_set_i,
    input  logic               ie_clr_i,
    input  logic               accept_i,
    input  logic               mask_wr_i,
    input  logic [NUM_RST-1:0] mask_i,
    output logic               ie_o,
    output logic [NUM_RST-1:0] mask_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ie_o   <= 1'b0;
            mask_o <= '1;
        end else begin
            if (accept_i)      ie_o <= 1'b0;
            else if (ie_clr_i) ie_o <= 1'b0;
            else if (ie_set_i) ie_o <= 1'b1;
            if (mask_wr_i) mask_o <= mask_i;
        end
    end

    // R6
    accept_clears_ie_chk: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> !ie_o);

    // R6
    clear_beats_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ie_clr_i && ie_set_i) |=> !ie_o);

endmodule

// File: rtl/rirq_arbiter.sv
module rirq_arbiter
    import rirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               boundary_i,
    input  logic               ie_i,
    input  logic [NUM_RST-1:0] mask_i,
    input  req_s               raw_i,
    output logic               pending_o,
    output src_e               win_o,
    output grant_s             grant_o
);
    req_s elig;

    always_comb begin
        elig.nmi = raw_i.nmi;
        elig.r7  = raw_i.r7  & ie_i & ~mask_i[2];
        elig.r6  = raw_i.r6  & ie_i & ~mask_i[1];
        elig.r5  = raw_i.r5  & ie_i & ~mask_i[0];
        elig.gen = raw_i.gen & ie_i;
        win_o     = pick_src(elig);
        pending_o = (win_o != SRC_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_o <= '0;
        end else if (boundary_i && pending_o) begin
            grant_o.take    <= 1'b1;
            grant_o.src     <= win_o;
            grant_o.vec     <= vec_of(win_o);
            grant_o.gen_ack <= (win_o == SRC_GEN);
        end else begin
            grant_o <= '0;
        end
    end

    // R4
    grant_needs_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        grant_o.take |-> $past(boundary_i && pending_o));

    // R1
    take_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        grant_o.take == (grant_o.src != SRC_NONE));

    // R10
    gen_ack_only_general_chk: assert property (@(posedge clk) disable iff (rst)
        grant_o.gen_ack |-> (grant_o.take && grant_o.src == SRC_GEN));

endmodule

// File: rtl/restart_irq_ctrl.sv
module restart_irq_ctrl
    import rirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               boundary_i,
    input  logic               nmi_i,
    input  logic               rs7_i,
    input  logic               rs6_i,
    input  logic               rs5_i,
    input  logic               gen_req_i,
    input  logic               ie_set_i,
    input  logic               ie_clr_i,
    input  logic               mask_wr_i,
    input  logic [NUM_RST-1:0] mask_i,
    output logic               pending_o,
    output logic               take_o,
    output logic [2:0]         src_o,
    output logic [VEC_W-1:0]   vector_o,
    output logic               gen_ack_o,
    output logic               ie_o,
    output logic [STAT_W-1:0]  pend_o
);
    logic               nmi_lat, r7_lat;
    logic               accept;
    logic [NUM_RST-1:0] mask_q;
    src_e               win;
    grant_s             grant;
    req_s               raw;

    assign accept = boundary_i & pending_o;

    rirq_edge_latch #(.NEED_LEVEL(1'b1)) u_nmi_lat (
        .clk   (clk),
        .rst   (rst),
        .in_i  (nmi_i),
        .clr_i (accept && win == SRC_NMI),
        .lat_o (nmi_lat)
    );

    rirq_edge_latch #(.NEED_LEVEL(1'b0)) u_r7_lat (
        .clk   (clk),
        .rst   (rst),
        .in_i  (rs7_i),
        .clr_i (accept && win == SRC_R7),
        .lat_o (r7_lat)
    );

    always_comb begin
        raw.nmi = nmi_lat;
        raw.r7  = r7_lat;
        raw.r6  = rs6_i;
        raw.r5  = rs5_i;
        raw.gen = gen_req_i;
    end

    rirq_enable_reg u_en (
        .clk       (clk),
        .rst       (rst),
        .ie_set_i  (ie_set_i),
        .ie_clr_i  (ie_clr_i),
        .accept_i  (accept),
        .mask_wr_i (mask_wr_i),
        .mask_i    (mask_i),
        .ie_o      (ie_o),
        .mask_o    (mask_q)
    );

    rirq_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (boundary_i),
        .ie_i       (ie_o),
        .mask_i     (mask_q),
        .raw_i      (raw),
        .pending_o  (pending_o),
        .win_o      (win),
        .grant_o    (grant)
    );

    assign take_o    = grant.take;
    assign src_o     = grant.src;
    assign vector_o  = grant.vec;
    assign gen_ack_o = grant.gen_ack;
    assign pend_o    = raw;

    // R2
    nmi_always_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && nmi_lat) |=> (take_o && src_o == SRC_NMI));

    // R7
    masked_r6_never_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (take_o && src_o == SRC_R6) |-> !$past(mask_q[1]));

    // R7
    masked_r7_never_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (take_o && src_o == SRC_R7) |-> !$past(mask_q[2]));

    // R6
    grant_leaves_ie_low_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> !ie_o);

    // R5
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!take_o && !ie_o && mask_q == '1));

    // R3
    r7_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (take_o && src_o == SRC_R7) |-> vector_o == 16'h003C);

endmodule

// File: tb/sim_restart_irq_ctrl.sv
module sim_restart_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary_i = 1'b0;
    logic        nmi_i = 1'b0, rs7_i = 1'b0, rs6_i = 1'b0, rs5_i = 1'b0, gen_req_i = 1'b0;
    logic        ie_set_i = 1'b0, ie_clr_i = 1'b0, mask_wr_i = 1'b0;
    logic [2:0]  mask_i = 3'b000;
    logic        pending_o, take_o, gen_ack_o, ie_o;
    logic [2:0]  src_o;
    logic [15:0] vector_o;
    logic [4:0]  pend_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    restart_irq_ctrl u0 (
        .clk(clk), .rst(rst), .boundary_i(boundary_i),
        .nmi_i(nmi_i), .rs7_i(rs7_i), .rs6_i(rs6_i), .rs5_i(rs5_i), .gen_req_i(gen_req_i),
        .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i), .mask_wr_i(mask_wr_i), .mask_i(mask_i),
        .pending_o(pending_o), .take_o(take_o), .src_o(src_o), .vector_o(vector_o),
        .gen_ack_o(gen_ack_o), .ie_o(ie_o), .pend_o(pend_o)
    );

    // entry: {ie, mask[2:0], rs7, rs6, rs5, gen, expected src[2:0]}
    localparam logic [10:0] TBL [10] = '{
        {1'b1, 3'b000, 4'b1111, 3'd4},
        {1'b1, 3'b000, 4'b0111, 3'd3},
        {1'b1, 3'b000, 4'b0011, 3'd2},
        {1'b1, 3'b000, 4'b0001, 3'd1},
        {1'b1, 3'b100, 4'b1100, 3'd3},
        {1'b1, 3'b110, 4'b1110, 3'd2},
        {1'b1, 3'b111, 4'b1111, 3'd1},
        {1'b0, 3'b000, 4'b1111, 3'd0},
        {1'b1, 3'b111, 4'b1110, 3'd0},
        {1'b1, 3'b011, 4'b0110, 3'd0}
    };

    function automatic logic [15:0] exp_vec(logic [2:0] s);
        case (s)
            3'd5: return 16'h0024;
            3'd4: return 16'h003C;
            3'd3: return 16'h0034;
            3'd2: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; boundary_i = 1'b0;
        {nmi_i, rs7_i, rs6_i, rs5_i, gen_req_i} = '0;
        {ie_set_i, ie_clr_i, mask_wr_i} = '0;
        step();
        rst = 1'b0;
    endtask

    task automatic setup(logic ie, logic [2:0] m);
        ie_set_i = ie; mask_wr_i = 1'b1; mask_i = m;
        step();
        ie_set_i = 1'b0; mask_wr_i = 1'b0;
    endtask

    // pulse boundary for one edge and check the grant in the cycle after it
    task automatic boundary_check(string req, logic [2:0] exp_src);
        boundary_i = 1'b1;
        chk(req, "pending", pending_o, exp_src != 3'd0);
        step();
        boundary_i = 1'b0;
        chk(req, "take", take_o, exp_src != 3'd0);
        chk(req, "src", src_o, exp_src);
        chk(req, "vector", vector_o, exp_vec(exp_src));
        chk(req, "gen_ack", gen_ack_o, exp_src == 3'd1);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step();
        do_reset();
        step();
        // R5 reset state
        chk("R5", "take", take_o, 0);
        chk("R5", "ie", ie_o, 0);
        chk("R5", "src", src_o, 0);
        chk("R5", "vector", vector_o, 0);
        chk("R5", "pend", pend_o, 0);
        // R5: masks set after reset, so rs6 alone with ie on is not eligible
        ie_set_i = 1'b1; step(); ie_set_i = 1'b0;
        rs6_i = 1'b1;
        chk("R5", "masked after reset", pending_o, 0);

        // R1 R7 R8 table: priority, masking, enable
        foreach (TBL[i]) begin
            do_reset();
            setup(TBL[i][10], TBL[i][9:7]);
            {rs7_i, rs6_i, rs5_i, gen_req_i} = TBL[i][6:3];
            step();
            boundary_check("R1", TBL[i][2:0]);
            step();
            chk("R10", "take one cycle", take_o, 0);
            chk("R6", "ie after", ie_o, (TBL[i][2:0] != 3'd0) ? 1'b0 : TBL[i][10]);
        end

        // R2 R3 nmi ignores enable and masks, beats rs7
        do_reset();
        setup(1'b0, 3'b111);
        nmi_i = 1'b1; rs7_i = 1'b1;
        step();
        boundary_check("R2", 3'd5);
        step();
        // R7 masked rs7 visible, nmi latch consumed
        chk("R7", "pend", pend_o, 5'b01000);
        // R9 held nmi fires once
        boundary_check("R9", 3'd0);

        // R9 short nmi pulse is lost
        nmi_i = 1'b0; step();
        nmi_i = 1'b1; step();
        nmi_i = 1'b0; step();
        boundary_check("R9", 3'd0);

        // R8 rs7 latched once, rs6 level persists
        do_reset();
        setup(1'b1, 3'b000);
        rs7_i = 1'b1; rs6_i = 1'b1;
        step();
        boundary_check("R8", 3'd4);
        ie_set_i = 1'b1; step(); ie_set_i = 1'b0;
        chk("R8", "rs7 latch cleared", pend_o[3], 0);
        boundary_check("R8", 3'd3);
        // R8 rs5 level dropped before boundary
        ie_set_i = 1'b1; rs6_i = 1'b0; rs5_i = 1'b1; step();
        ie_set_i = 1'b0; rs5_i = 1'b0; step();
        boundary_check("R8", 3'd0);

        // R4 no grant without boundary
        do_reset();
        setup(1'b1, 3'b000);
        gen_req_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R4", "take w/o boundary", take_o, 0);
            chk("R11", "pending", pending_o, 1);
        end
        chk("R11", "pend gen bit", pend_o, 5'b00001);
        boundary_check("R10", 3'd1);
        step();
        chk("R10", "gen_ack one cycle", gen_ack_o, 0);
        // R6 grant cleared ie, still-high gen blocked
        boundary_check("R6", 3'd0);

        // R6 clear wins over set
        ie_set_i = 1'b1; step();
        chk("R6", "ie set", ie_o, 1);
        ie_set_i = 1'b1; ie_clr_i = 1'b1; step();
        ie_set_i = 1'b0; ie_clr_i = 1'b0;
        chk("R6", "clear beats set", ie_o, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule